// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a register of `WIDTH` stages with four clocked behaviours: it can keep its contents, move them one place toward the high end, move them one place toward the low end, or capture a whole word from its parallel lines. Two select bits choose the behaviour at each rising clock edge. Each direction of movement has its own serial input. The two end stages are always visible on dedicated serial outputs, so several of these registers can be chained.

The parallel lines are meant to be shared between input and output on a bus. To keep the block synthesizable, each line is split into a captured input (`par_in`), the register value (`par_out`) and a single drive enable (`par_oe`). The chip's pad logic merges them into a tri-state line. Two active-low enables gate the drive. The drive is also withdrawn in capture mode, so the lines can carry incoming data. An active-low clear empties the register at once, without waiting for the clock.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is 0, every stage reads 0 at once, without waiting for a clock edge. `par_out`, `first_q` and `last_q` are then all 0.
- R2: The register changes only at a rising edge of `clk`. Input changes between edges leave `par_out` unchanged.
- R3: With `mode_sel` = 2'b00 (keep), a rising edge leaves every stage unchanged.
- R4: With `mode_sel` = 2'b01, a rising edge moves each stage i into stage i+1. `ser_up_in` enters stage 0 and the old top stage is dropped.
- R5: With `mode_sel` = 2'b10, a rising edge moves each stage i into stage i-1. `ser_down_in` enters stage `WIDTH-1` and the old stage 0 is dropped.
- R6: With `mode_sel` = 2'b11, a rising edge copies `par_in` into the register, with bit i going to stage i.
- R7: `par_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11.
- R8: `par_oe` has no effect on the register. `par_out` always carries the stage values, so keep, shift, capture and clear behave the same with the drive on or off.
- R9: `first_q` always equals stage 0 and `last_q` always equals stage `WIDTH-1`, whatever the state of the drive enables.
- R10: Clear wins over any clock edge that arrives while `clr_n` is 0. The first edge after `clr_n` returns to 1 acts according to the `mode_sel` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Mode: 00 keep, 01 shift up, 10 shift down, 11 capture |
| oe_a_n | input | 1 | First parallel drive enable, active low |
| oe_b_n | input | 1 | Second parallel drive enable, active low |
| ser_up_in | input | 1 | Serial bit entering stage 0 when shifting up |
| ser_down_in | input | 1 | Serial bit entering the top stage when shifting down |
| par_in | input | WIDTH | Value sampled from the parallel lines |
| par_out | output | WIDTH | Register value offered to the parallel lines |
| par_oe | output | 1 | Drive enable for the parallel lines |
| first_q | output | 1 | Stage 0, always driven |
| last_q | output | 1 | Top stage, always driven |

## Verification
The bench builds the block with its default `WIDTH` of 8. This keeps every stage and both end stages easy to follow against an arithmetic model. The bench sweeps all four modes against all four combinations of the drive enables, using pseudo-random words and serial bits. With eight stages, a full pass of a serial bit from one end to the other, and out again, happens within the sweep. The bench also applies a clear in the middle of a sequence, holds a clear across a clock edge, and changes inputs between edges.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_CAPT = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] cur_q,
  input  logic             ser_up_in,
  input  logic             ser_down_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] nxt_q
);
  usr_mode_e mode;
  assign mode = usr_mode_e'(mode_sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_low
      assign from_below = ser_up_in;
    end else begin : g_mid_low
      assign from_below = cur_q[i-1];
    end
    if (i == WIDTH - 1) begin : g_high
      assign from_above = ser_down_in;
    end else begin : g_mid_high
      assign from_above = cur_q[i+1];
    end
    always_comb begin
      case (mode)
        MODE_UP:   nxt_q[i] = from_below;
        MODE_DOWN: nxt_q[i] = from_above;
        MODE_CAPT: nxt_q[i] = par_in[i];
        default:   nxt_q[i] = cur_q[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_port_ctrl.sv
module usr_port_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output logic       par_oe
);
  logic capturing;
  assign capturing = (usr_mode_e'(mode_sel) == MODE_CAPT);
  assign par_oe    = ~(oe_a_n | oe_b_n | capturing);
endmodule

// File: rtl/usr_stage_bank.sv
module usr_stage_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt_q,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt_q;
  end

  // R10: an edge seen while clear is held leaves the bank empty
  p_clear_wins_r10: assert property (@(posedge clk) !clr_n |-> (q == '0))
    else $error("clear lost to clock edge");
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_up_in,
  input  logic             ser_down_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] par_out,
  output logic             par_oe,
  output logic             first_q,
  output logic             last_q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nxt_q;

  usr_next_state #(.WIDTH(WIDTH)) u_next (
    .mode_sel    (mode_sel),
    .cur_q       (q),
    .ser_up_in   (ser_up_in),
    .ser_down_in (ser_down_in),
    .par_in      (par_in),
    .nxt_q       (nxt_q)
  );

  usr_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt_q (nxt_q),
    .q     (q)
  );

  usr_port_ctrl u_port (
    .mode_sel (mode_sel),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .par_oe   (par_oe)
  );

  assign par_out = q;
  assign first_q = q[0];
  assign last_q  = q[TOP];

  p_keep_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b00) |=> (q == $past(q)))
    else $error("keep mode changed the register");

  p_up_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b01) |=> (q == {$past(q[TOP-1:0]), $past(ser_up_in)}))
    else $error("upward shift mismatch");

  p_down_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b10) |=> (q == {$past(ser_down_in), $past(q[TOP:1])}))
    else $error("downward shift mismatch");

  p_capture_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b11) |=> (q == $past(par_in)))
    else $error("capture mismatch");

  p_no_drive_capture_r7: assert property (@(posedge clk)
    (mode_sel == 2'b11) |-> !par_oe)
    else $error("drive on during capture");

  p_no_drive_disabled_r7: assert property (@(posedge clk)
    (oe_a_n || oe_b_n) |-> !par_oe)
    else $error("drive on with an enable high");

  p_clear_r1: assert property (@(posedge clk)
    !clr_n |-> (par_out == '0 && !first_q && !last_q))
    else $error("outputs not empty during clear");
endmodule

// File: tb/usr_shift_reg_tb.sv
module usr_shift_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode_sel = 2'b00;
  logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic         ser_up_in = 1'b0, ser_down_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;
  logic         par_oe, first_q, last_q;

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] model = '0;
  logic [15:0]  lfsr = 16'hACE1;
  bit done = 0;

  usr_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel), .oe_a_n(oe_a_n),
    .oe_b_n(oe_b_n), .ser_up_in(ser_up_in), .ser_down_in(ser_down_in),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .first_q(first_q), .last_q(last_q)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic exp_oe;
    exp_oe = !oe_a_n && !oe_b_n && (mode_sel != 2'b11);
    chk(par_out == model, tag, int'(par_out), int'(model));
    chk(first_q == model[0], "R9 first_q", int'(first_q), int'(model[0]));
    chk(last_q == model[W-1], "R9 last_q", int'(last_q), int'(model[W-1]));
    chk(par_oe == exp_oe, "R7 par_oe", int'(par_oe), int'(exp_oe));
  endtask

  function automatic logic [W-1:0] next_model(input logic [1:0] m, input logic [W-1:0] cur,
                                              input logic su, input logic sd, input logic [W-1:0] pi);
    case (m)
      2'b01:   return (cur << 1) | W'(su);
      2'b10:   return (cur >> 1) | (W'(sd) << (W-1));
      2'b11:   return pi;
      default: return cur;
    endcase
  endfunction

  task automatic adv();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // drive at negedge, check R2 between edges, update model at the edge
  task automatic step(input logic [1:0] m, input logic ea, input logic eb, input string tag);
    @(negedge clk);
    adv();
    mode_sel = m; oe_a_n = ea; oe_b_n = eb;
    ser_up_in = lfsr[0]; ser_down_in = lfsr[5]; par_in = lfsr[15:8];
    #3;
    chk(par_out == model, "R2 no change between edges", int'(par_out), int'(model));
    check_all("R7/R9 drive and end stages");
    @(posedge clk);
    model = next_model(m, model, ser_up_in, ser_down_in, par_in);
    #2;
    check_all(tag);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3 keep";
      2'b01:   return "R4 shift up";
      2'b10:   return "R5 shift down";
      default: return "R6 capture";
    endcase
  endfunction

  initial begin
    #5;
    chk(par_out == '0 && !first_q && !last_q, "R1 reset state", int'(par_out), 0);
    @(negedge clk); clr_n = 1'b1;

    // sweep: every mode under every enable pair; R8 checked via par_out with drive off
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++) begin
        step(2'b11, e[0], e[1], "R6 capture seed");
        for (int k = 0; k < 10; k++)
          step(m[1:0], e[0], e[1], (e != 0) ? "R8 drive off" : mode_tag(m[1:0]));
      end

    // mixed sequence with enables toggling and mode changes
    for (int k = 0; k < 300; k++) begin
      adv();
      step(lfsr[3:2], lfsr[6], lfsr[9], "R8 mixed sequence");
    end

    // clear mid-sequence, between edges
    step(2'b11, 1'b0, 1'b0, "R6 capture");
    @(negedge clk); #2; clr_n = 1'b0; #1;
    model = '0;
    chk(par_out == '0, "R1 async clear", int'(par_out), 0);
    chk(!first_q && !last_q, "R1 serial outs cleared", int'({first_q, last_q}), 0);
    // clear held across an edge with capture of all ones requested
    mode_sel = 2'b11; par_in = '1;
    @(posedge clk); #2;
    chk(par_out == '0, "R10 clear beats edge", int'(par_out), 0);
    @(negedge clk);
    clr_n = 1'b1; mode_sel = 2'b11; par_in = 8'h5A;
    @(posedge clk); model = 8'h5A; #2;
    chk(par_out == 8'h5A, "R10 first edge after clear", int'(par_out), 8'h5A);
    // walk one serial bit through the whole register upward
    for (int k = 0; k < W + 2; k++) step(2'b01, 1'b0, 1'b1, "R4 shift up walk");
    for (int k = 0; k < W + 2; k++) step(2'b10, 1'b1, 1'b0, "R5 shift down walk");
    for (int k = 0; k < 4; k++) step(2'b00, 1'b0, 1'b0, "R3 keep");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule